// File: doc/BRIEF.md
# Vector BLAS1 Operation Unit

The unit runs one of three level-1 vector kernels over 16-bit signed fixed-point data that lives in a RAM inside the block. A single command selects the kernel by opcode and supplies two base addresses, a common stride, an element count and a Q8.8 scalar. The kernels are a search for the element of largest magnitude (the result is its position in the vector), an in-place scale of one vector, and an in-place scaled add of one vector into another.

Element `i` of a vector lives at `(base + i*stride) mod DEPTH`, so row and column vectors of a matrix stored in the RAM can both be walked. One signed multiplier serves every kernel. Results go back over the destination vector at one element per cycle once the read stage is full. While the unit is idle, the same RAM can be written and read through a plain memory port, which is how operands are loaded and results are fetched.

Top module: `blas1_unit`

## Requirements
- R1: After reset `busy_o` is 0, `done_o` is 0 and `idx_o` is 0.
- R2: A command is taken on a clock edge where `cmd_valid_i` is 1 and `busy_o` is 0. While `busy_o` is 1, `cmd_valid_i` and the command fields have no effect on memory contents, timing or `idx_o`.
- R3: Opcode 0 (search) sets `idx_o` to the smallest `i` whose `|v[i]|` is maximal over the vector at `cmd_x_base_i`. The magnitude of -32768 counts as 32768. Memory is left unchanged.
- R4: Opcode 1 (scale) replaces each `x[i]` at `cmd_x_base_i` with `sat16((alpha*x[i]) >>> 8)`.
- R5: Opcode 2 (axpy) replaces each `y[i]` at `cmd_y_base_i` with `sat16(((alpha*x[i]) >>> 8) + y[i])` and leaves the x vector unchanged.
- R6: `cmd_alpha_i` is signed Q8.8. The full 32-bit product is shifted arithmetically right by 8 (and, for axpy, y is added) before one saturation to [-32768, 32767].
- R7: Element `i` is addressed at `(base + i*stride) mod 256`. The stride is unsigned, so the address wraps at the end of the RAM.
- R8: For `len > 0`, `busy_o` is 1 for exactly `len+1` cycles, starting in the cycle after acceptance. `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls.
- R9: A command with `len = 0` writes nothing, returns `idx_o = 0` and keeps `busy_o` high for one cycle before `done_o`.
- R10: With `busy_o` at 0, a memory-port write (`mem_we_i`) lands at `mem_addr_i`, and `mem_rdata_o` shows the word at `mem_addr_i` one cycle later. Memory-port writes issued while `busy_o` is 1 are dropped.
- R11: Opcode 3 writes nothing and completes with the timing of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 search, 1 scale, 2 axpy, 3 none |
| cmd_x_base_i | input | 8 | Base address of x |
| cmd_y_base_i | input | 8 | Base address of y (axpy) |
| cmd_stride_i | input | 8 | Element stride in words |
| cmd_len_i | input | 8 | Element count |
| cmd_alpha_i | input | 16 | Scalar, signed Q8.8 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| idx_o | output | 8 | Search result index |
| mem_we_i | input | 1 | Memory port write enable |
| mem_addr_i | input | 8 | Memory port address |
| mem_wdata_i | input | 16 | Memory port write data |
| mem_rdata_o | output | 16 | Memory port read data, one-cycle latency |

## Verification
The assertions rely on a nonzero stride and on x and y vectors that do not share addresses within one axpy. The block does not guard against a read-after-write hazard inside its one-stage read pipeline. Every table entry and directed test uses disjoint regions, including the case where the x vector wraps past address 255. The reference model applies each kernel in element order to a mirror of the RAM. Every word is then read back through the memory port, so any stray write also shows up.

// File: rtl/blas1_pkg.sv
package blas1_pkg;
  typedef enum logic [1:0] {
    OP_AMAX = 2'd0,
    OP_SCAL = 2'd1,
    OP_AXPY = 2'd2,
    OP_NOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_FINISH = 2'd2
  } state_e;
endpackage

// File: rtl/blas1_ram.sv
module blas1_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] rb_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    ra_data_o <= mem_q[ra_addr_i];
    rb_data_o <= mem_q[rb_addr_i];
  end
endmodule

// File: rtl/blas1_alu.sv
module blas1_alu #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] alpha_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic                 add_y_i,
  output logic        [DW-1:0] res_o,
  output logic        [DW:0]   mag_o
);
  localparam int SW = 2 * DW + 1;
  localparam logic signed [SW-1:0] SMAX = {{(DW + 2){1'b0}}, {(DW - 1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {{(DW + 2){1'b1}}, {(DW - 1){1'b0}}};

  logic signed [2*DW-1:0] prod;
  logic signed [SW-1:0]   prod_sh;
  logic signed [SW-1:0]   y_ext;
  logic signed [SW-1:0]   sum;
  logic signed [DW:0]     x_ext;

  // single shared multiplier
  assign prod    = alpha_i * x_i;
  assign prod_sh = SW'(prod >>> FRAC);
  assign y_ext   = add_y_i ? SW'(y_i) : '0;
  assign sum     = prod_sh + y_ext;

  always_comb begin
    if (sum > SMAX)      res_o = SMAX[DW-1:0];
    else if (sum < SMIN) res_o = SMIN[DW-1:0];
    else                 res_o = sum[DW-1:0];
  end

  assign x_ext = {x_i[DW-1], x_i};
  assign mag_o = x_ext[DW] ? DW'(0) - x_ext : x_ext;
endmodule

// File: rtl/blas1_unit.sv
module blas1_unit
  import blas1_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int LW   = 8,
  parameter int FRAC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_x_base_i,
  input  logic [AW-1:0] cmd_y_base_i,
  input  logic [AW-1:0] cmd_stride_i,
  input  logic [LW-1:0] cmd_len_i,
  input  logic [DW-1:0] cmd_alpha_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [LW-1:0] idx_o,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [DW-1:0] mem_wdata_i,
  output logic [DW-1:0] mem_rdata_o
);
  state_e        state_q;
  op_e           op_q;
  logic [DW-1:0] alpha_q;
  logic [AW-1:0] stride_q, xa_q, ya_q;
  logic [LW-1:0] len_q, cnt_q;
  logic          s1_valid_q;
  logic [LW-1:0] s1_idx_q;
  logic [AW-1:0] s1_wa_q;
  logic [LW-1:0] best_idx_q;
  logic [DW:0]   best_mag_q;
  logic          done_q;

  logic          accept;
  logic          eng_we;
  logic          ram_we;
  logic [AW-1:0] ram_wa, ram_ra;
  logic [DW-1:0] ram_wd, x_data, y_data;
  logic [DW-1:0] alu_res;
  logic [DW:0]   alu_mag;

  assign accept = cmd_valid_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign idx_o  = best_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_NOP;
      alpha_q    <= '0;
      stride_q   <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      xa_q       <= '0;
      ya_q       <= '0;
      s1_valid_q <= 1'b0;
      s1_idx_q   <= '0;
      s1_wa_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      s1_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q     <= op_e'(cmd_op_i);
            alpha_q  <= cmd_alpha_i;
            stride_q <= cmd_stride_i;
            len_q    <= cmd_len_i;
            cnt_q    <= '0;
            xa_q     <= cmd_x_base_i;
            ya_q     <= cmd_y_base_i;
            state_q  <= (cmd_len_i == '0) ? ST_FINISH : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          s1_valid_q <= 1'b1;
          s1_idx_q   <= cnt_q;
          s1_wa_q    <= (op_q == OP_AXPY) ? ya_q : xa_q;
          xa_q       <= xa_q + stride_q;
          ya_q       <= ya_q + stride_q;
          cnt_q      <= cnt_q + LW'(1);
          if (cnt_q == len_q - LW'(1)) state_q <= ST_FINISH;
        end
        ST_FINISH: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // search stage: strict compare keeps the lowest index on ties
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_idx_q <= '0;
      best_mag_q <= '0;
    end else if (accept) begin
      best_idx_q <= '0;
      best_mag_q <= '0;
    end else if (s1_valid_q && op_q == OP_AMAX &&
                 (s1_idx_q == '0 || alu_mag > best_mag_q)) begin
      best_idx_q <= s1_idx_q;
      best_mag_q <= alu_mag;
    end
  end

  assign eng_we = s1_valid_q && (op_q == OP_SCAL || op_q == OP_AXPY);
  assign ram_we = eng_we || (mem_we_i && state_q == ST_IDLE);
  assign ram_wa = eng_we ? s1_wa_q : mem_addr_i;
  assign ram_wd = eng_we ? alu_res : mem_wdata_i;
  assign ram_ra = (state_q == ST_IDLE) ? mem_addr_i : xa_q;
  assign mem_rdata_o = x_data;

  blas1_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk_i     (clk_i),
    .ra_addr_i (ram_ra),
    .rb_addr_i (ya_q),
    .we_i      (ram_we),
    .wa_i      (ram_wa),
    .wd_i      (ram_wd),
    .ra_data_o (x_data),
    .rb_data_o (y_data)
  );

  blas1_alu #(.DW(DW), .FRAC(FRAC)) u_alu (
    .alpha_i (alpha_q),
    .x_i     (x_data),
    .y_i     (y_data),
    .add_y_i (op_q == OP_AXPY),
    .res_o   (alu_res),
    .mag_o   (alu_mag)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));
  // R10
  eng_wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |-> busy_o);
  // R3
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_AMAX && len_q != '0) |-> (idx_o < len_q));
endmodule

// File: tb/blas1_unit_tb.sv
module blas1_unit_tb;
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  xb;
    logic [7:0]  yb;
    logic [7:0]  st;
    logic [7:0]  len;
    logic [15:0] al;
  } vec_t;

  // op, x base, y base, stride, len, alpha
  localparam vec_t TBL [0:8] = '{
    '{2'd0, 8'd0,   8'd0,   8'd1,  8'd16, 16'h0000},
    '{2'd1, 8'd16,  8'd0,   8'd1,  8'd8,  16'h0180},
    '{2'd2, 8'd32,  8'd64,  8'd1,  8'd12, 16'hFF00},
    '{2'd1, 8'd100, 8'd0,   8'd3,  8'd10, 16'h7FFF},
    '{2'd2, 8'd0,   8'd200, 8'd16, 8'd4,  16'h0240},
    '{2'd0, 8'd130, 8'd0,   8'd5,  8'd20, 16'h0000},
    '{2'd2, 8'd250, 8'd120, 8'd2,  8'd6,  16'h8000},
    '{2'd3, 8'd10,  8'd20,  8'd1,  8'd5,  16'h0100},
    '{2'd0, 8'd40,  8'd0,   8'd1,  8'd0,  16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_xb = '0, cmd_yb = '0, cmd_st = '0, cmd_len = '0;
  logic [15:0] cmd_al = '0;
  logic        busy, done;
  logic [7:0]  idx;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_addr = '0;
  logic [15:0] mem_wdata = '0;
  logic [15:0] mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic signed [15:0] mir [256];

  always #2.5 clk = ~clk;

  blas1_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_x_base_i(cmd_xb), .cmd_y_base_i(cmd_yb),
    .cmd_stride_i(cmd_st), .cmd_len_i(cmd_len), .cmd_alpha_i(cmd_al),
    .busy_o(busy), .done_o(done), .idx_o(idx),
    .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] sat16(input longint v);
    if (v > 32767) return 16'sd32767;
    if (v < -32768) return -16'sd32768;
    return 16'(v);
  endfunction

  task automatic mem_wr(input int a, input int v);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = 8'(a); mem_wdata = 16'(v);
    @(negedge clk);
    mem_we = 1'b0;
    mir[a] = 16'(v);
  endtask

  task automatic verify_mem(input string req);
    int bad = 0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      mem_addr = 8'(a);
      @(negedge clk);
      if (mem_rdata !== mir[a]) begin
        bad++;
        chk(1'b0, req, $sformatf("mem[%0d]", a), int'($signed(mem_rdata)), int'(mir[a]));
      end
    end
    chk(bad == 0, req, "memory image mismatches", bad, 0);
  endtask

  // reference model, applied in element order to the mirror
  task automatic model(input vec_t v, output int exp_idx);
    longint p, s, bm, m;
    int xa, ya;
    exp_idx = 0;
    bm = -1;
    for (int i = 0; i < int'(v.len); i++) begin
      xa = (int'(v.xb) + i * int'(v.st)) % 256;
      ya = (int'(v.yb) + i * int'(v.st)) % 256;
      p = longint'($signed(v.al)) * longint'(mir[xa]);
      s = p >>> 8;
      case (v.op)
        2'd0: begin
          m = (mir[xa] < 0) ? -longint'(mir[xa]) : longint'(mir[xa]);
          if (m > bm) begin bm = m; exp_idx = i; end
        end
        2'd1: mir[xa] = sat16(s);
        2'd2: mir[ya] = sat16(s + longint'(mir[ya]));
        default: ;
      endcase
    end
  endtask

  // poke: drive a second command and a memory write while busy (R2, R10)
  task automatic run(input vec_t v, input string req, input bit poke);
    int cyc = 0;
    int exp_idx;
    int exp_cyc;
    model(v, exp_idx);
    exp_cyc = int'(v.len) + 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_xb = v.xb; cmd_yb = v.yb;
    cmd_st = v.st; cmd_len = v.len; cmd_al = v.al;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (poke && cyc == 1) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_xb = 8'd240; cmd_len = 8'd4;
        cmd_al = 16'h0000;
        mem_we = 1'b1; mem_addr = 8'd250; mem_wdata = 16'h1234;
      end
      if (poke && cyc == 2) begin
        cmd_valid = 1'b0; mem_we = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0; mem_we = 1'b0;
    chk(cyc == exp_cyc, "R8", {req, " busy cycles"}, cyc, exp_cyc);
    chk(done == 1'b1, "R8", {req, " done at busy fall"}, int'(done), 1);
    if (v.op == 2'd0)
      chk(idx == 8'(exp_idx), req, "search index", int'(idx), exp_idx);
    @(negedge clk);
    chk(done == 1'b0, "R8", {req, " done width"}, int'(done), 0);
    verify_mem(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(idx == 8'd0, "R1", "idx after reset", int'(idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after release", int'(busy), 0);

    // R10 load through the memory port
    for (int a = 0; a < 256; a++)
      mem_wr(a, ((a * 2749 + 1021) % 65536) - 32768);
    verify_mem("R10");

    // table walk: R3 R4 R5 R6 R7 R9 R11 (entry 6 wraps x past 255)
    for (int k = 0; k < 9; k++) begin
      case (TBL[k].op)
        2'd0: run(TBL[k], (TBL[k].len == 0) ? "R9" : "R3", 1'b0);
        2'd1: run(TBL[k], (TBL[k].st != 1) ? "R7" : "R4", 1'b0);
        2'd2: run(TBL[k], (k == 6) ? "R7" : ((k == 2) ? "R6" : "R5"), 1'b0);
        default: run(TBL[k], "R11", 1'b0);
      endcase
    end

    // R3 tie on magnitude keeps the lowest index
    mem_wr(230, 5); mem_wr(231, -7); mem_wr(232, 7); mem_wr(233, 3);
    v = '{2'd0, 8'd230, 8'd0, 8'd1, 8'd4, 16'h0000};
    run(v, "R3", 1'b0);
    // R3 -32768 beats 32767
    mem_wr(234, 32767); mem_wr(235, -32768); mem_wr(236, 100);
    v = '{2'd0, 8'd234, 8'd0, 8'd1, 8'd3, 16'h0000};
    run(v, "R3", 1'b0);

    // R6 saturation on both ends of axpy
    mem_wr(60, 32000); mem_wr(61, -32000); mem_wr(62, 256);
    mem_wr(70, 20000); mem_wr(71, -20000); mem_wr(72, -1);
    v = '{2'd2, 8'd60, 8'd70, 8'd1, 8'd3, 16'h0200};
    run(v, "R6", 1'b0);

    // R2 R10 second command and memory write while busy are dropped
    v = '{2'd1, 8'd16, 8'd0, 8'd2, 8'd6, 16'hFF80};
    run(v, "R2", 1'b1);
    chk(mir[250] != 16'sh1234, "R10", "busy write target preserved", int'(mir[250]), int'(mir[250]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule